// File: doc/BRIEF.md
# External Bus Write Cycle Controller

This block carries one write transfer from an internal master out onto an asynchronous external memory bus. The master presents an address, a 32-bit write word, a size code, an access type code and a chip-select request for one clock. The controller stores these values and then steps the external pins through three parts. The first phase drives the address and the codes. Wait states follow, one bus clock at a time, until an acknowledge arrives. The final phase ends the transfer. When that phase completes, the controller signals completion back to the master.

The controller runs on a clock at twice the bus rate, so each bus half-clock takes one `clk` cycle. Each phase, and each wait state, lasts two `clk` cycles. The transfer is ended by either of two acknowledges: one from the external slave, and one from the internal chip-select logic. Both are sampled only in the last cycle of the first phase and in the last cycle of each wait state. The byte strobes use big-endian lane order. Narrow write data is copied across all lanes, so whichever lane the slave reads holds the right byte.

Top module: `ebus_wr_ctrl`

## Requirements
- R1: While reset is held, and whenever no transfer is active, `busy`, `done`, `bus_cs`, `bus_oe`, `bus_be` and `bus_data_oe` are all 0 and `bus_rw` is 1.
- R2: A request is accepted only when `req_valid` is 1 in a cycle where `busy` is 0. A `req_valid` raised while `busy` is 1 changes no output and starts no transfer.
- R3: The first phase lasts two cycles. In its first cycle the address, size, type and chip select (`bus_cs` = captured `req_cs`) are driven, with `bus_rw` 1, `bus_oe` 0 and no strobes. In its second cycle `bus_rw` is 0 and the strobes are asserted.
- R4: Strobe bit 3 covers D[31:24], which is byte offset 0, and bit 0 covers D[7:0], which is offset 3. Size 01 (byte) asserts only bit 3−addr[1:0]. Size 10 (halfword) asserts 1100 when addr[1]=0 and 0011 when addr[1]=1. Size 00 (word) and size 11 assert 1111.
- R5: `bus_data` carries the low byte copied four times for size 01, the low halfword copied twice for size 10, and the full word for sizes 00 and 11. Lane enable bit 1 (D[31:16]) is set when strobe bit 3 or bit 2 applies, and lane enable bit 0 (D[15:0]) is set when strobe bit 1 or bit 0 applies.
- R6: If `ext_ack` or `cs_ack` is 1 in the second cycle of the first phase, no wait state occurs. The final phase follows at once, and data lanes are first enabled in its first cycle.
- R7: Otherwise wait states of two cycles each are inserted, with strobes still asserted. The data lanes are enabled from the first cycle of the first wait state onward. An acknowledge seen in the second cycle of a wait state ends the waiting.
- R8: An acknowledge in any cycle other than the two sampling points named in R6 and R7 has no effect on the length of the cycle.
- R9: The final phase lasts two cycles. The strobes stay asserted in its first cycle and are 0 in its second. Through both cycles the address, data, lane enables, `bus_rw`=0, chip select, type and size stay driven.
- R10: `busy` is 1 from the cycle after acceptance through the last final-phase cycle, so it lasts 4 + 2·(wait states) cycles. `done` is a one-cycle pulse in the cycle after that, and a new request may be accepted in that cycle.
- R11: `bus_addr`, `bus_data`, `bus_size`, `bus_type` and `bus_cs` do not change between consecutive cycles in which `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bus rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request, held for one cycle |
| req_addr | input | AW | Byte address of the write |
| req_wdata | input | 32 | Write data, right-aligned for narrow sizes |
| req_size | input | 2 | 01 byte, 10 halfword, 00 word (11 acts as word) |
| req_type | input | 3 | Access type code passed to the bus |
| req_cs | input | 1 | Assert chip select for this transfer |
| ext_ack | input | 1 | Transfer acknowledge from the external slave, active high |
| cs_ack | input | 1 | Acknowledge from internal chip-select logic, active high |
| bus_addr | output | AW | External address |
| bus_size | output | 2 | External size code |
| bus_type | output | 3 | External access type code |
| bus_cs | output | 1 | Chip select, active high |
| bus_oe | output | 1 | Memory output enable, held negated for writes |
| bus_rw | output | 1 | 1 read/idle, 0 write |
| bus_be | output | 4 | Byte strobes, bit 3 = D[31:24] |
| bus_data | output | 32 | Write data bus |
| bus_data_oe | output | 2 | Drive enables: bit 1 for D[31:16], bit 0 for D[15:0] |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some rules are checked on every cycle. The bus is quiet while idle. The first cycle has `bus_rw` high with no strobes, and the second has `bus_rw` low with strobes. A byte write asserts exactly one strobe, and wait states always drive data. An early acknowledge skips waiting. Strobes are clear in the closing cycle, `done` is a single pulse, and the captured fields hold steady throughout a transfer. Other behaviours can only be shown by the bench's scenarios against its reference model:
- the exact strobe and lane patterns for each size and offset,
- the byte copying on the data bus,
- the counted length of a transfer for a given number of wait states,
- that acknowledges at the wrong moments and requests raised mid-transfer are ignored.

// File: rtl/ebus_wr_pkg.sv
package ebus_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_X1A  = 3'd1,
    ST_X1B  = 3'd2,
    ST_WA   = 3'd3,
    ST_WB   = 3'd4,
    ST_X2A  = 3'd5,
    ST_X2B  = 3'd6
  } wr_state_e;

  localparam logic [1:0] SZ_WORD = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_HALF = 2'b10;

  // Strobe pattern, big-endian: bit 3 is byte offset 0.
  function automatic logic [3:0] strobe_for(input logic [1:0] sz, input logic [1:0] ofs);
    logic [3:0] r;
    case (sz)
      SZ_BYTE: r = 4'b1000 >> ofs;
      SZ_HALF: r = ofs[1] ? 4'b0011 : 4'b1100;
      default: r = 4'b1111;
    endcase
    return r;
  endfunction

  // Narrow data copied across every lane.
  function automatic logic [31:0] lane_data(input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] r;
    case (sz)
      SZ_BYTE: r = {4{d[7:0]}};
      SZ_HALF: r = {2{d[15:0]}};
      default: r = d;
    endcase
    return r;
  endfunction

  // 16-bit lane drive enables from a strobe pattern.
  function automatic logic [1:0] half_enables(input logic [3:0] be);
    return {be[3] | be[2], be[1] | be[0]};
  endfunction

endpackage

// File: rtl/ebus_wr_seq.sv
module ebus_wr_seq
  import ebus_wr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      ack,
  output wr_state_e st,
  output logic      done_o
);

  wr_state_e st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (start) st_nx = ST_X1A;
      ST_X1A:  st_nx = ST_X1B;
      ST_X1B:  st_nx = ack ? ST_X2A : ST_WA;
      ST_WA:   st_nx = ST_WB;
      ST_WB:   st_nx = ack ? ST_X2A : ST_WA;
      ST_X2A:  st_nx = ST_X2B;
      ST_X2B:  st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      done_o <= 1'b0;
    end else begin
      st     <= st_nx;
      done_o <= (st == ST_X2B);
    end
  end

endmodule

// File: rtl/ebus_wr_capture.sv
module ebus_wr_capture #(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int SW = 2,
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [SW-1:0] size_i,
  input  logic [TW-1:0] type_i,
  input  logic          cs_i,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic [SW-1:0] size_q,
  output logic [TW-1:0] type_q,
  output logic          cs_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      size_q <= '0;
      type_q <= '0;
      cs_q   <= 1'b0;
    end else if (load) begin
      addr_q <= addr_i;
      data_q <= data_i;
      size_q <= size_i;
      type_q <= type_i;
      cs_q   <= cs_i;
    end
  end

endmodule

// File: rtl/ebus_wr_lanes.sv
module ebus_wr_lanes
  import ebus_wr_pkg::*;
(
  input  wr_state_e   st,
  input  logic [1:0]  size_q,
  input  logic [1:0]  ofs_q,
  input  logic [31:0] data_q,
  input  logic        cs_q,
  output logic        rw_o,
  output logic        cs_o,
  output logic [3:0]  be_o,
  output logic [31:0] data_o,
  output logic [1:0]  data_oe_o
);

  logic [3:0] strobe;
  logic       in_xfer, write_phase, strobe_phase, data_phase;

  assign strobe       = strobe_for(size_q, ofs_q);
  assign in_xfer      = (st != ST_IDLE);
  assign write_phase  = in_xfer && (st != ST_X1A);
  assign strobe_phase = (st == ST_X1B) || (st == ST_WA) || (st == ST_WB) || (st == ST_X2A);
  assign data_phase   = (st == ST_WA) || (st == ST_WB) || (st == ST_X2A) || (st == ST_X2B);

  assign rw_o      = !write_phase;
  assign cs_o      = in_xfer && cs_q;
  assign be_o      = strobe_phase ? strobe : 4'b0000;
  assign data_o    = lane_data(size_q, data_q);
  assign data_oe_o = data_phase ? half_enables(strobe) : 2'b00;

endmodule

// File: rtl/ebus_wr_ctrl.sv
module ebus_wr_ctrl
  import ebus_wr_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic [1:0]    req_size,
  input  logic [2:0]    req_type,
  input  logic          req_cs,
  input  logic          ext_ack,
  input  logic          cs_ack,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [2:0]    bus_type,
  output logic          bus_cs,
  output logic          bus_oe,
  output logic          bus_rw,
  output logic [3:0]    bus_be,
  output logic [31:0]   bus_data,
  output logic [1:0]    bus_data_oe,
  output logic          busy,
  output logic          done
);

  localparam int DW = 32;

  wr_state_e     st;
  logic          accept, ack_any;
  logic [DW-1:0] data_q;

  // Named events for the checker
  logic ev_ack_x1, ev_wait, ev_x2_end;

  assign ack_any   = ext_ack | cs_ack;
  assign accept    = req_valid && (st == ST_IDLE);
  assign ev_ack_x1 = (st == ST_X1B) && ack_any;
  assign ev_wait   = (st == ST_WA) || (st == ST_WB);
  assign ev_x2_end = (st == ST_X2B);

  ebus_wr_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .ack    (ack_any),
    .st     (st),
    .done_o (done)
  );

  ebus_wr_capture #(.AW(AW), .DW(DW), .SW(2), .TW(3)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .addr_i (req_addr),
    .data_i (req_wdata),
    .size_i (req_size),
    .type_i (req_type),
    .cs_i   (req_cs),
    .addr_q (bus_addr),
    .data_q (data_q),
    .size_q (bus_size),
    .type_q (bus_type),
    .cs_q   (cs_q_w)
  );

  logic cs_q_w;

  ebus_wr_lanes u_lanes (
    .st        (st),
    .size_q    (bus_size),
    .ofs_q     (bus_addr[1:0]),
    .data_q    (data_q),
    .cs_q      (cs_q_w),
    .rw_o      (bus_rw),
    .cs_o      (bus_cs),
    .be_o      (bus_be),
    .data_o    (bus_data),
    .data_oe_o (bus_data_oe)
  );

  assign busy   = (st != ST_IDLE);
  assign bus_oe = 1'b0;

endmodule

// File: rtl/ebus_wr_ctrl_chk.sv
module ebus_wr_ctrl_chk
  import ebus_wr_pkg::*;
#(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic [2:0]    bus_type,
  input logic          bus_cs,
  input logic          bus_rw,
  input logic [3:0]    bus_be,
  input logic [31:0]   bus_data,
  input logic [1:0]    bus_data_oe,
  input logic          ev_ack_x1,
  input logic          ev_wait,
  input logic          ev_x2_end
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_be == 4'b0 && bus_data_oe == 2'b0 && !bus_cs && bus_rw));

  a_r3_first_cycle_read_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_rw && bus_be == 4'b0));

  a_r3_second_cycle_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> (!bus_rw && bus_be != 4'b0));

  a_r4_byte_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_size == SZ_BYTE && bus_be != 4'b0) |-> ($countones(bus_be) == 1));

  a_r6_early_ack_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_x1 |=> (!ev_wait && bus_data_oe != 2'b0));

  a_r7_wait_drives_data: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wait |-> (bus_data_oe != 2'b0 && bus_be != 4'b0));

  a_r9_strobes_off_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    ev_x2_end |-> (bus_be == 4'b0 && !bus_rw && bus_data_oe != 2'b0));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    ev_x2_end |=> (done && !busy));

  a_r11_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(bus_addr) && $stable(bus_data) &&
      $stable(bus_size) && $stable(bus_type) && $stable(bus_cs)));

endmodule

bind ebus_wr_ctrl ebus_wr_ctrl_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .bus_addr    (bus_addr),
  .bus_size    (bus_size),
  .bus_type    (bus_type),
  .bus_cs      (bus_cs),
  .bus_rw      (bus_rw),
  .bus_be      (bus_be),
  .bus_data    (bus_data),
  .bus_data_oe (bus_data_oe),
  .ev_ack_x1   (ev_ack_x1),
  .ev_wait     (ev_wait),
  .ev_x2_end   (ev_x2_end)
);

// File: tb/ebus_wr_ctrl_test.sv
module ebus_wr_ctrl_test;
  localparam int AW = 24;

  localparam int P_IDLE = 0, P_X1A = 1, P_X1B = 2, P_WA = 3, P_WB = 4, P_X2A = 5, P_X2B = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [1:0]    req_size = '0;
  logic [2:0]    req_type = '0;
  logic          req_cs = 1'b0;
  logic          ext_ack = 1'b0;
  logic          cs_ack = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [2:0]    bus_type;
  logic          bus_cs, bus_oe, bus_rw, busy, done;
  logic [3:0]    bus_be;
  logic [31:0]   bus_data;
  logic [1:0]    bus_data_oe;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  // Reference model state
  int            ph = P_IDLE;
  bit            m_done = 0;
  bit            m_waited = 0;
  logic [AW-1:0] m_addr = '0;
  logic [31:0]   m_wd = '0;
  logic [1:0]    m_sz = '0;
  logic [2:0]    m_ty = '0;
  logic          m_cs = 0;

  always #10 clk = ~clk;

  ebus_wr_ctrl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_size(req_size), .req_type(req_type), .req_cs(req_cs),
    .ext_ack(ext_ack), .cs_ack(cs_ack), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_type(bus_type), .bus_cs(bus_cs), .bus_oe(bus_oe), .bus_rw(bus_rw),
    .bus_be(bus_be), .bus_data(bus_data), .bus_data_oe(bus_data_oe),
    .busy(busy), .done(done)
  );

  function automatic logic [3:0] m_be(input logic [1:0] sz, input logic [1:0] a);
    if (sz == 2'b01) return 4'(8 >> a);
    if (sz == 2'b10) return (a >= 2) ? 4'd3 : 4'd12;
    return 4'd15;
  endfunction

  function automatic logic [31:0] m_data(input logic [1:0] sz, input logic [31:0] d);
    if (sz == 2'b01) return {24'd0, d[7:0]} * 32'h01010101;
    if (sz == 2'b10) return {16'd0, d[15:0]} * 32'h00010001;
    return d;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Behavioural reference, advanced on each edge
  always @(posedge clk) begin
    cyc++;
    m_done = 0;
    if (!rst_n) begin
      ph = P_IDLE;
    end else begin
      case (ph)
        P_IDLE: if (req_valid) begin
          m_addr = req_addr; m_wd = req_wdata; m_sz = req_size;
          m_ty = req_type; m_cs = req_cs; m_waited = 0; ph = P_X1A;
        end
        P_X1A: ph = P_X1B;
        P_X1B: begin
          if (ext_ack || cs_ack) ph = P_X2A;
          else begin ph = P_WA; m_waited = 1; end
        end
        P_WA: ph = P_WB;
        P_WB: ph = (ext_ack || cs_ack) ? P_X2A : P_WA;
        P_X2A: ph = P_X2B;
        default: begin ph = P_IDLE; m_done = 1; end
      endcase
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] e_be;
      logic [1:0] e_oe;
      bit strb, dat;
      strb = (ph == P_X1B) || (ph == P_WA) || (ph == P_WB) || (ph == P_X2A);
      dat  = (ph == P_WA) || (ph == P_WB) || (ph == P_X2A) || (ph == P_X2B);
      e_be = m_be(m_sz, m_addr[1:0]);
      e_oe = {e_be[3] | e_be[2], e_be[1] | e_be[0]};
      chk(32'(busy), 32'(ph != P_IDLE), "R10", "busy");
      chk(32'(done), 32'(m_done), "R10", "done");
      chk(32'(bus_cs), 32'((ph != P_IDLE) && m_cs), "R3", "cs");
      chk(32'(bus_rw), 32'(ph == P_IDLE || ph == P_X1A), "R3", "rw");
      chk(32'(bus_oe), 32'd0, "R3", "oe");
      chk(32'(bus_be), strb ? 32'(e_be) : 32'd0, "R4", "strobes");
      chk(32'(bus_data_oe), dat ? 32'(e_oe) : 32'd0, m_waited ? "R7" : "R6", "lane enables");
      if (ph != P_IDLE) begin
        chk(32'(bus_addr), 32'(m_addr), "R11", "addr");
        chk(32'(bus_size), 32'(m_sz), "R11", "size");
        chk(32'(bus_type), 32'(m_ty), "R11", "type");
        chk(bus_data, m_data(m_sz, m_wd), "R5", "data");
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic set_ack(input bit use_cs);
    if (use_cs) cs_ack = 1'b1; else ext_ack = 1'b1;
  endtask

  task automatic xfer(input logic [AW-1:0] a, input logic [31:0] d, input logic [1:0] sz,
                      input logic [2:0] ty, input logic cs, input int nwait,
                      input bit use_cs, input bit noise);
    int t0;
    req_addr = a; req_wdata = d; req_size = sz; req_type = ty; req_cs = cs;
    req_valid = 1'b1;
    tick();                                   // first phase, cycle 1
    t0 = cyc;
    req_valid = 1'b0;
    if (noise) ext_ack = 1'b1;                // R8: not a sampling point
    tick();                                   // first phase, cycle 2
    ext_ack = 1'b0; cs_ack = 1'b0;
    if (nwait == 0) set_ack(use_cs);          // R6
    tick();
    for (int i = 0; i < nwait; i++) begin     // R7
      ext_ack = 1'b0; cs_ack = 1'b0;
      if (noise) cs_ack = 1'b1;               // R8: first wait cycle ignored
      tick();
      cs_ack = 1'b0;
      if (i == nwait - 1) set_ack(use_cs);
      tick();
    end
    ext_ack = 1'b0; cs_ack = 1'b0;            // final phase, cycle 1
    if (noise) begin
      req_valid = 1'b1; req_addr = ~a;        // R2: request while busy
      ext_ack = 1'b1;
    end
    tick();                                   // final phase, cycle 2
    req_valid = 1'b0; ext_ack = 1'b0;
    chk(32'(bus_be), 32'd0, "R9", "strobes in last cycle");
    chk(32'(bus_addr), 32'(a), noise ? "R2" : "R9", "addr in last cycle");
    tick();                                   // done cycle
    chk(32'(done), 32'd1, "R10", "done pulse");
    chk(32'(busy), 32'd0, "R2", "no restart from ignored request");
    chk(32'(cyc - t0), 32'(4 + 2 * nwait), noise ? "R8" : "R10", "transfer length");
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        while (wd < 20000) begin @(posedge clk); wd++; end
        n_err++;
        $display("FAIL watchdog: actual %0d expected < %0d cycles", wd, 20000);
        finish_run();
      end
    join_none

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: quiet bus during reset
    chk(32'(busy), 32'd0, "R1", "busy in reset");
    chk(32'(done), 32'd0, "R1", "done in reset");
    chk(32'(bus_cs), 32'd0, "R1", "cs in reset");
    chk(32'(bus_rw), 32'd1, "R1", "rw in reset");
    chk(32'(bus_be), 32'd0, "R1", "strobes in reset");
    chk(32'(bus_data_oe), 32'd0, "R1", "lanes in reset");
    chk(32'(bus_oe), 32'd0, "R1", "oe in reset");
    tick();
    rst_n = 1'b1;
    tick();
    chk(32'(busy), 32'd0, "R1", "busy idle after reset");

    // Bytes at every offset, no wait, back to back
    for (int k = 0; k < 4; k++)
      xfer(24'h001230 + 24'(k), 32'hA1B2C3D4 + 32'(k), 2'b01, 3'(k), 1'b1, 0, 1'b0, 1'b0);
    // Halfwords on both halves, one wait, internal acknowledge
    xfer(24'h004000, 32'h1111BEEF, 2'b10, 3'd5, 1'b1, 1, 1'b1, 1'b0);
    xfer(24'h004002, 32'h2222CAFE, 2'b10, 3'd6, 1'b0, 1, 1'b1, 1'b0);
    xfer(24'h004003, 32'h33335A5A, 2'b10, 3'd2, 1'b1, 0, 1'b0, 1'b0);
    // Word with three waits and stray acknowledges / requests
    xfer(24'h0ABCDC, 32'hDEADBEEF, 2'b00, 3'd7, 1'b1, 3, 1'b0, 1'b1);
    // Size 11 acts as word
    xfer(24'h000101, 32'h01234567, 2'b11, 3'd1, 1'b1, 2, 1'b1, 1'b1);
    // Byte without chip select, stray acknowledges
    xfer(24'hFFFFF1, 32'h000000C3, 2'b01, 3'd4, 1'b0, 0, 1'b0, 1'b1);
    repeat (3) tick();
    chk(32'(done), 32'd0, "R10", "done cleared");
    finish_run();
  end

endmodule